// File: doc/BRIEF.md
# Two-by-two cut-through packet switch

This block moves packets from two input ports to two output ports. A packet is a sequence of phits on a valid/ready channel. The first phit is the header, and a last flag marks the final phit. The switch looks only at the destination field of the header. A fixed route table turns that field into an output port. Once the output is won, the rest of the packet follows on the same output phit by phit. Forwarding starts as soon as the header has been accepted and does not wait for the tail.

Each input has a buffer that holds one packet of the maximum length. When the wanted output is busy, or its receiver is stalling, the phits of a packet collect in that buffer. The input still accepts phits until the buffer is full. When the output becomes free, the buffered phits drain at once, even if the tail has not arrived yet. If every hop is blocked, the whole packet is stored before it moves on, which is store-and-forward behaviour. An output belongs to one packet from the moment its header is granted until the phit with the last flag leaves. Two inputs that compete for a free output in the same cycle are served in round-robin order.

Top module: `ct_xbar2`

## Requirements
- R1: The destination is bits [DEST_W-1:0] of the header phit. The header goes to the output given by bit d of ROUTE_MAP for destination d. With the defaults (DEST_W=2, ROUTE_MAP=4'b1010), destination d goes to output d mod 2.
- R2: When the output is idle and ready, a header accepted on a clock edge is presented as valid on its output right after that edge. This happens before any later phit of the packet has been sent.
- R3: An input drops in_ready only when its buffer holds MAX_LEN phits. It never holds more than that.
- R4: With its output blocked, an input accepts a whole packet of MAX_LEN phits without stalling. The header is held on the output during that time.
- R5: When a blocked output becomes ready, the buffered header is presented at once, even though the packet's later phits have not arrived yet.
- R6: Once an output has been granted to a packet, it carries only that packet's phits until the phit with the last flag has been transferred. Packets never interleave.
- R7: An output is released in the cycle after its last phit transfers. A waiting header from the other input can then be granted.
- R8: When both inputs ask for the same free output in the same cycle, the input that did not win the previous grant on that output wins. After reset, input 0 is preferred.
- R9: No phit is lost, duplicated or reordered. Packets from one input leave in the order they arrived.
- R10: After reset, both in_ready bits are 1 and both out_valid bits are 0.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 2 | Phit valid, one bit per input |
| in_ready | output | 2 | Input can take a phit |
| in_data | input | 2*W | Phit data, input i at bits [i*W +: W] |
| in_last | input | 2 | Phit is the last of its packet |
| out_valid | output | 2 | Phit valid, one bit per output |
| out_ready | input | 2 | Receiver takes the phit |
| out_data | output | 2*W | Phit data, output o at bits [o*W +: W] |
| out_last | output | 2 | Phit is the last of its packet |

## Verification
The bench targets five corner cases:
- A header sent into an idle path must appear one cycle later while its tail is still pending. A store-first design would show nothing there.
- A packet of full length sent against a stalled output must go in without a single wait state. A buffer sized one short would stall on the last phit.
- The output is released on the last phit while the other input is waiting. A missed release would hang, and an early release would let packets interleave, which the per-phit tag check catches.
- Two rounds of contention on one output must come out in the order 0,1 and then 0,1,0. A fixed-priority arbiter gives 0,0,1 in the second round.
- A long random run with random stalls checks every phit's sequence number, source and index, so any lost, doubled or reordered phit is caught.

// File: rtl/ct_xbar2.sv
module ct_xbar2 #(
  parameter int W = 8,
  parameter int MAX_LEN = 4,
  parameter int DEST_W = 2,
  parameter logic [(1<<DEST_W)-1:0] ROUTE_MAP = 4'b1010
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     in_valid,
  output logic [1:0]     in_ready,
  input  logic [2*W-1:0] in_data,
  input  logic [1:0]     in_last,
  output logic [1:0]     out_valid,
  input  logic [1:0]     out_ready,
  output logic [2*W-1:0] out_data,
  output logic [1:0]     out_last
);
  localparam int DEPTH = MAX_LEN;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = W + 1;

  logic [PW-1:0] head [2];
  logic [CW-1:0] fill [2];
  logic [1:0] nonempty, owns, want, pop;
  logic [1:0] lock_v, lock_s, sel_s, sel_v, fire;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < 2; i++) begin : g_in
    logic [PW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic push;

    assign in_ready[i] = (cnt != CW'(DEPTH));
    assign push        = in_valid[i] && in_ready[i];
    assign head[i]     = mem[rp];
    assign nonempty[i] = (cnt != '0);
    assign want[i]     = ROUTE_MAP[mem[rp][DEST_W-1:0]];
    assign fill[i]     = cnt;
    assign owns[i]     = (lock_v[0] && lock_s[0] == 1'(i)) || (lock_v[1] && lock_s[1] == 1'(i));
    assign pop[i]      = (fire[0] && sel_s[0] == 1'(i)) || (fire[1] && sel_s[1] == 1'(i));

    always_ff @(posedge clk)
      if (push) mem[wp] <= {in_last[i], in_data[i*W +: W]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push)   wp <= step(wp);
        if (pop[i]) rp <= step(rp);
        cnt <= cnt + CW'(push) - CW'(pop[i]);
      end
    end
  end

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic lv, ls, rr;
    logic req0, req1, gany, gs;

    assign req0 = nonempty[0] && !owns[0] && (want[0] == 1'(o));
    assign req1 = nonempty[1] && !owns[1] && (want[1] == 1'(o));
    assign gany = !lv && (req0 || req1);
    assign gs   = (req0 && req1) ? rr : req1;

    assign sel_s[o] = lv ? ls : gs;
    assign sel_v[o] = lv || gany;
    assign lock_v[o] = lv;
    assign lock_s[o] = ls;

    assign out_valid[o]       = sel_v[o] && nonempty[sel_s[o]];
    assign out_data[o*W +: W] = head[sel_s[o]][W-1:0];
    assign out_last[o]        = head[sel_s[o]][W];
    assign fire[o]            = out_valid[o] && out_ready[o];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lv <= 1'b0;
        ls <= 1'b0;
        rr <= 1'b0;
      end else begin
        if (fire[o] && out_last[o]) lv <= 1'b0;
        else if (gany) begin
          lv <= 1'b1;
          ls <= gs;
        end
        if (gany) rr <= ~gs;
      end
    end
  end
endmodule

// File: rtl/ct_xbar2_chk.sv
module ct_xbar2_chk #(
  parameter int W = 8,
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     in_ready,
  input logic [1:0]     out_valid,
  input logic [1:0]     out_ready,
  input logic [2*W-1:0] out_data,
  input logic [1:0]     out_last,
  input logic [1:0]     lock_v,
  input logic [1:0]     lock_s,
  input logic [CW-1:0]  fill [2]
);
  for (genvar i = 0; i < 2; i++) begin : g_i
    assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready[i] |-> fill[i] == CW'(DEPTH));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill[i] <= CW'(DEPTH));
  end

  for (genvar o = 0; o < 2; o++) begin : g_o
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o*W +: W]) && $stable(out_last[o]));
    assert_keep_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_v[o] && !(out_valid[o] && out_ready[o] && out_last[o]) |=> lock_v[o] && $stable(lock_s[o]));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && out_ready[o] && out_last[o] |=> !lock_v[o]);
  end

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_v == 2'b11 |-> lock_s[0] != lock_s[1]);
endmodule

bind ct_xbar2 ct_xbar2_chk #(.W(W), .DEPTH(MAX_LEN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .lock_v(lock_v), .lock_s(lock_s), .fill(fill)
);

// File: tb/ct_xbar2_tb.sv
module ct_xbar2_tb;
  localparam int W = 8;
  localparam int MAX_LEN = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [2*W-1:0] in_data, out_data;

  ct_xbar2 #(.W(W), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int exp_len [2][32];
  int tx_seq [2], rx_seq [2], tx_pkts [2], rx_pkts [2], sent_phits [2], stalls [2];
  int hlog [2][256];
  int hn [2];
  bit in_pkt [2];
  int cur_src [2], cur_seq [2], cur_idx [2];
  bit rand_on;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send_phit(input int i, input logic [W-1:0] d, input logic l);
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_data[i*W +: W] = d;
    in_last[i] = l;
    #1;
    while (!in_ready[i]) begin
      stalls[i]++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid[i] = 1'b0;
  endtask

  task automatic send_pkt(input int i, input int dest, input int len, input int gap, input bit probe);
    int q;
    logic [W-1:0] d;
    q = tx_seq[i] % 32;
    exp_len[i][q] = len;
    tx_seq[i]++;
    sent_phits[i] = 0;
    for (int k = 0; k < len; k++) begin
      if (k == 0) d = {5'(q), 1'(i), 2'(dest)};
      else        d = {5'(q), 1'(i), 2'(k)};
      send_phit(i, d, k == len - 1);
      sent_phits[i]++;
      if (probe && k == 0) begin
        check(out_valid[dest % 2] == 1'b1, "R2 cut-through valid", int'(out_valid[dest % 2]), 1);
        check(out_data[(dest % 2)*W +: W] == d, "R2 cut-through header", int'(out_data[(dest % 2)*W +: W]), int'(d));
      end
      if (k < len - 1) repeat (gap) @(negedge clk);
    end
    tx_pkts[i]++;
  endtask

  // output monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      for (int o = 0; o < 2; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          logic [W-1:0] d;
          int s, q;
          d = out_data[o*W +: W];
          if (!in_pkt[o]) begin
            s = int'(d[2]);
            q = int'(d[7:3]);
            check(int'(d[1:0]) % 2 == o, "R1 route", o, int'(d[1:0]) % 2);
            check(q == rx_seq[s] % 32, "R9 packet order", q, rx_seq[s] % 32);
            if (hn[o] < 256) hlog[o][hn[o]] = s;
            hn[o]++;
            cur_src[o] = s;
            cur_seq[o] = q;
            cur_idx[o] = 0;
            in_pkt[o] = 1'b1;
          end else begin
            cur_idx[o]++;
            check(d == {5'(cur_seq[o]), 1'(cur_src[o]), 2'(cur_idx[o])}, "R6 R9 body phit",
                  int'(d), int'({5'(cur_seq[o]), 1'(cur_src[o]), 2'(cur_idx[o])}));
          end
          if (out_last[o]) begin
            check(cur_idx[o] + 1 == exp_len[cur_src[o]][cur_seq[o]], "R9 packet length",
                  cur_idx[o] + 1, exp_len[cur_src[o]][cur_seq[o]]);
            rx_seq[cur_src[o]]++;
            rx_pkts[cur_src[o]]++;
            in_pkt[o] = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    int b0, b1;
    rst_n = 1'b0;
    in_valid = '0;
    in_last = '0;
    in_data = '0;
    out_ready = '0;
    for (int i = 0; i < 2; i++) begin
      tx_seq[i] = 0; rx_seq[i] = 0; tx_pkts[i] = 0; rx_pkts[i] = 0;
      hn[i] = 0; in_pkt[i] = 1'b0; stalls[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(in_ready == 2'b11, "R10 in_ready", int'(in_ready), 3);
    check(out_valid == 2'b00, "R10 out_valid", int'(out_valid), 0);

    // R8 round A: simultaneous single-phit packets to output 0
    b0 = hn[0];
    fork
      send_pkt(0, 0, 1, 0, 0);
      send_pkt(1, 0, 1, 0, 0);
    join
    @(negedge clk);
    out_ready[0] = 1'b1;
    repeat (5) @(negedge clk);
    check(hn[0] - b0 == 2, "R8 round A count", hn[0] - b0, 2);
    check(hlog[0][b0] == 0, "R8 round A first", hlog[0][b0], 0);
    check(hlog[0][b0+1] == 1, "R8 round A second", hlog[0][b0+1], 1);

    // R8 and R7 round B: input 0 contends twice
    out_ready[0] = 1'b0;
    b0 = hn[0];
    fork
      begin send_pkt(0, 2, 1, 0, 0); send_pkt(0, 0, 1, 0, 0); end
      send_pkt(1, 2, 1, 0, 0);
    join
    @(negedge clk);
    out_ready[0] = 1'b1;
    repeat (6) @(negedge clk);
    check(hn[0] - b0 == 3, "R7 round B count", hn[0] - b0, 3);
    check(hlog[0][b0] == 0, "R8 round B first", hlog[0][b0], 0);
    check(hlog[0][b0+1] == 1, "R8 round B second", hlog[0][b0+1], 1);
    check(hlog[0][b0+2] == 0, "R8 round B third", hlog[0][b0+2], 0);

    // R2 cut-through on an idle path
    send_pkt(0, 0, MAX_LEN, 0, 1);
    repeat (4) @(negedge clk);

    // R4 and R3: whole packet into a blocked output
    out_ready[0] = 1'b0;
    stalls[0] = 0;
    send_pkt(0, 0, MAX_LEN, 0, 0);
    check(stalls[0] == 0, "R4 no stall while buffering", stalls[0], 0);
    check(in_ready[0] == 1'b0, "R3 ready low when full", int'(in_ready[0]), 0);
    check(in_ready[1] == 1'b1, "R3 other input ready", int'(in_ready[1]), 1);
    check(out_valid[0] == 1'b1 && out_data[W-1:0] == {5'((tx_seq[0] - 1) % 32), 1'b0, 2'd0},
          "R4 header held", int'(out_data[W-1:0]), int'({5'((tx_seq[0] - 1) % 32), 1'b0, 2'd0}));
    @(negedge clk);
    out_ready[0] = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    check(in_ready[0] == 1'b1, "R3 ready back after drain", int'(in_ready[0]), 1);
    check(rx_pkts[0] == tx_pkts[0], "R9 drained", rx_pkts[0], tx_pkts[0]);

    // R5 partial cut-through
    out_ready[0] = 1'b0;
    fork
      send_pkt(0, 0, MAX_LEN, 3, 0);
      begin
        repeat (3) @(negedge clk);
        out_ready[0] = 1'b1;
        #1;
        check(out_valid[0] == 1'b1, "R5 resume valid", int'(out_valid[0]), 1);
        check(out_data[W-1:0] == {5'((tx_seq[0] - 1) % 32), 1'b0, 2'd0}, "R5 resume header",
              int'(out_data[W-1:0]), int'({5'((tx_seq[0] - 1) % 32), 1'b0, 2'd0}));
        check(sent_phits[0] < MAX_LEN, "R5 tail not yet sent", sent_phits[0], 1);
      end
    join
    repeat (4) @(negedge clk);

    // R1 route table
    out_ready = 2'b11;
    b0 = hn[0];
    b1 = hn[1];
    for (int d = 0; d < 4; d++) send_pkt(1, d, 1, 0, 0);
    repeat (4) @(negedge clk);
    check(hn[0] - b0 == 2, "R1 headers on output 0", hn[0] - b0, 2);
    check(hn[1] - b1 == 2, "R1 headers on output 1", hn[1] - b1, 2);

    // R9 random traffic with random stalls
    rand_on = 1'b1;
    fork
      begin
        fork
          for (int n = 0; n < 60; n++)
            send_pkt(0, int'($urandom % 4), 1 + int'($urandom % MAX_LEN), int'($urandom % 3), 0);
          for (int n = 0; n < 60; n++)
            send_pkt(1, int'($urandom % 4), 1 + int'($urandom % MAX_LEN), int'($urandom % 3), 0);
        join
        rand_on = 1'b0;
      end
      while (rand_on) begin
        @(negedge clk);
        out_ready = 2'($urandom);
      end
    join
    @(negedge clk);
    out_ready = 2'b11;
    repeat (20) @(negedge clk);
    #1;
    check(rx_pkts[0] == tx_pkts[0], "R9 all packets from input 0", rx_pkts[0], tx_pkts[0]);
    check(rx_pkts[1] == tx_pkts[1], "R9 all packets from input 1", rx_pkts[1], tx_pkts[1]);
    check(out_valid == 2'b00, "R9 no extra phits", int'(out_valid), 0);
    check(in_ready == 2'b11, "R3 ready after idle", int'(in_ready), 3);
    report();
  end
endmodule